// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device and decides when a program or erase inside that device has finished. After a `start` request it reads the device status byte over a simple bus master port. It compares one chosen toggle bit across consecutive reads. A bit that holds still between two reads means the operation is complete. A bit that keeps flipping means the device is still busy, unless the timeout flag (status bit 5) has risen.

When bit 5 is seen high, the poller takes a fresh pair of reads to confirm the result. This catches a toggle bit that stops in the same cycle the timeout flag rises. If the confirmation pair still toggles, the operation failed. The poller then writes the reset command so the device goes back to array reads.

An optional read budget ends a run that never settles. That run finishes with a separate limit-fail flag and also gets the reset write. `abort` drops the run at once, and the next `start` always begins again from a fresh read pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Out of reset the block is idle: `busStrobe`, `done`, `pass`, `fail` and `limitFail` are all low.
- R2: A run begins with two status reads from `pollAddr`. If the selected toggle bit is equal in both reads, the run ends with `pass` and no bus write.
- R3: If the toggle bit differs and bit 5 of the latest read is 0, polling goes on. Each further read is compared with the read just before it, until a read leaves the toggle bit unchanged.
- R4: If the toggle bit differs and bit 5 of the latest read is 1, the block does a new pair of reads. If the toggle bit is equal within that pair, the run ends with `pass`.
- R5: If the confirmation pair still toggles, the run ends with `fail`. Before `done` rises the block makes exactly one bus write, with data 8'hF0 to `pollAddr`.
- R6: `toggleSel` = 0 compares status bit 6 and `toggleSel` = 1 compares status bit 2. Changes in the unselected bit have no effect on the result.
- R7: When `pollLimit` is nonzero, a run with no verdict by its `pollLimit`-th read ends with `limitFail` after the reset write. A pass or fail decided on that same read takes priority. `pollLimit` = 0 means no limit.
- R8: `abort` returns the block to idle. `busStrobe` drops on the next cycle and `done` does not rise. A later `start` begins again with a fresh read pair.
- R9: While `busStrobe` is high and `busReady` is low, `busAddr`, `busWrite` and `busWdata` hold steady. A transfer completes in each cycle where both `busStrobe` and `busReady` are high.
- R10: `done` stays high until the next `start` or `abort`. While `done` is high, exactly one of `pass`, `fail` and `limitFail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (taken when idle or done) |
| abort | input | 1 | Drop the current run and return to idle |
| toggleSel | input | 1 | 0 selects bit 6, 1 selects bit 2 as toggle bit |
| pollLimit | input | CNT_W | Read budget per run, 0 for unlimited |
| pollAddr | input | ADDR_W | Status/command address of the device |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busWrite | output | 1 | 1 for write, 0 for read |
| busStrobe | output | 1 | Transfer request |
| busRdata | input | DATA_W | Bus read data, valid with busReady |
| busReady | input | 1 | Transfer accepted this cycle |
| done | output | 1 | Run finished |
| pass | output | 1 | Operation completed |
| fail | output | 1 | Toggling persisted after timeout flag |
| limitFail | output | 1 | Read budget exhausted without verdict |

## Verification
The hardest case to reach is the read where the timeout flag and the end of toggling arrive together. A single-pass poller would call that read a failure. The bench reaches it by scripting status bytes in which bit 5 rises on a read that still toggles, followed by two equal reads. A second script keeps toggling through the confirmation pair and exhausts the read budget on that same read, which shows that a verdict beats the limit.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_CMP,
    ST_CONF_A,
    ST_CONF_B,
    ST_RSTWR,
    ST_DONE
  } pollState_t;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_PASS,
    RES_FAIL,
    RES_LIMIT
  } pollResult_t;

  typedef struct packed {
    logic issueRead;
    logic issueWrite;
    logic latchCfg;
  } dpCtl_t;

endpackage

// File: rtl/tpoll_datapath.sv
module tpoll_datapath
  import tpoll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int BIT_A     = 6,
  parameter int BIT_B     = 2,
  parameter int FLAG_BIT  = 5,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              toggleSel,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic [ADDR_W-1:0] pollAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrite,
  output logic              busStrobe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              xferDone,
  output logic              toggled,
  output logic              flagHigh,
  output logic              lastRead
);

  logic              selQ;
  logic [CNT_W-1:0]  limitQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  readCount;
  logic              refBit;
  logic              curBit;

  assign busStrobe = ctl.issueRead | ctl.issueWrite;
  assign busWrite  = ctl.issueWrite;
  assign busAddr   = addrQ;
  assign busWdata  = ctl.issueWrite ? RESET_CMD : '0;
  assign xferDone  = busStrobe & busReady;

  assign curBit   = selQ ? busRdata[BIT_B] : busRdata[BIT_A];
  assign toggled  = curBit != refBit;
  assign flagHigh = busRdata[FLAG_BIT];
  assign lastRead = (limitQ != '0) && (readCount == limitQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ      <= 1'b0;
      limitQ    <= '0;
      addrQ     <= '0;
      readCount <= '0;
      refBit    <= 1'b0;
    end else if (ctl.latchCfg) begin
      selQ      <= toggleSel;
      limitQ    <= pollLimit;
      addrQ     <= pollAddr;
      readCount <= '0;
      refBit    <= 1'b0;
    end else if (xferDone && ctl.issueRead) begin
      readCount <= readCount + 1'b1;
      refBit    <= curBit;
    end
  end

  assert_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (limitQ != '0) |-> (readCount <= limitQ));

endmodule

// File: rtl/tpoll_control.sv
module tpoll_control
  import tpoll_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   abort,
  input  logic   xferDone,
  input  logic   toggled,
  input  logic   flagHigh,
  input  logic   lastRead,
  output dpCtl_t ctl,
  output logic   done,
  output logic   pass,
  output logic   fail,
  output logic   limitFail
);

  pollState_t  state, stateNext;
  pollResult_t result, resultNext;

  always_comb begin
    ctl            = '0;
    ctl.issueRead  = (state == ST_FIRST) || (state == ST_CMP) ||
                     (state == ST_CONF_A) || (state == ST_CONF_B);
    ctl.issueWrite = (state == ST_RSTWR);
    ctl.latchCfg   = !abort && start &&
                     ((state == ST_IDLE) || (state == ST_DONE));
  end

  always_comb begin
    stateNext  = state;
    resultNext = result;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stateNext  = ST_FIRST;
          resultNext = RES_NONE;
        end
      end
      ST_FIRST, ST_CONF_A: begin
        if (xferDone) begin
          if (lastRead) begin
            stateNext  = ST_RSTWR;
            resultNext = RES_LIMIT;
          end else begin
            stateNext = (state == ST_FIRST) ? ST_CMP : ST_CONF_B;
          end
        end
      end
      ST_CMP: begin
        if (xferDone) begin
          if (!toggled) begin
            stateNext  = ST_DONE;
            resultNext = RES_PASS;
          end else if (lastRead) begin
            stateNext  = ST_RSTWR;
            resultNext = RES_LIMIT;
          end else if (flagHigh) begin
            stateNext = ST_CONF_A;
          end
        end
      end
      ST_CONF_B: begin
        if (xferDone) begin
          if (toggled) begin
            stateNext  = ST_RSTWR;
            resultNext = RES_FAIL;
          end else begin
            stateNext  = ST_DONE;
            resultNext = RES_PASS;
          end
        end
      end
      ST_RSTWR: begin
        if (xferDone) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (abort) begin
      stateNext  = ST_IDLE;
      resultNext = RES_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      result <= RES_NONE;
    end else begin
      state  <= stateNext;
      result <= resultNext;
    end
  end

  assign done      = (state == ST_DONE);
  assign pass      = done && (result == RES_PASS);
  assign fail      = done && (result == RES_FAIL);
  assign limitFail = done && (result == RES_LIMIT);

  assert_conf_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONF_B) |-> ($past(state) == ST_CONF_A || $past(state) == ST_CONF_B));

  assert_fail_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(state) == ST_RSTWR);

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              toggleSel,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic [ADDR_W-1:0] pollAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrite,
  output logic              busStrobe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              limitFail
);

  dpCtl_t ctl;
  logic   xferDone, toggled, flagHigh, lastRead;

  tpoll_control ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .xferDone(xferDone), .toggled(toggled), .flagHigh(flagHigh),
    .lastRead(lastRead), .ctl(ctl), .done(done), .pass(pass),
    .fail(fail), .limitFail(limitFail)
  );

  tpoll_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_CMD(RESET_CMD)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .toggleSel(toggleSel),
    .pollLimit(pollLimit), .pollAddr(pollAddr), .busAddr(busAddr),
    .busWdata(busWdata), .busWrite(busWrite), .busStrobe(busStrobe),
    .busRdata(busRdata), .busReady(busReady), .xferDone(xferDone),
    .toggled(toggled), .flagHigh(flagHigh), .lastRead(lastRead)
  );

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(pass || fail || limitFail));

  assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && busWrite) |-> (busWdata == RESET_CMD && busAddr == $past(busAddr)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busStrobe && !done));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && !busReady && !abort) |=>
      (busStrobe && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)));

  assert_verdict_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({pass, fail, limitFail}) == 1));

endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb_top;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] ADDR = 16'h0AAA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, abort = 1'b0, toggleSel = 1'b0;
  logic [CNT_W-1:0]  pollLimit = '0;
  logic [ADDR_W-1:0] pollAddr = ADDR;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic              busWrite, busStrobe;
  logic [DATA_W-1:0] busRdata = '0;
  logic              busReady = 1'b0;
  logic done, pass, fail, limitFail;

  always #2 clk = ~clk;

  toggle_poll_ctrl dut_i (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .toggleSel(toggleSel), .pollLimit(pollLimit), .pollAddr(pollAddr),
    .busAddr(busAddr), .busWdata(busWdata), .busWrite(busWrite),
    .busStrobe(busStrobe), .busRdata(busRdata), .busReady(busReady),
    .done(done), .pass(pass), .fail(fail), .limitFail(limitFail)
  );

  // Vector: script of status bytes (byte0 first), select, limit,
  // ready latency, expected result (1 pass, 2 fail, 3 limit), expected reads
  typedef struct packed {
    logic [63:0] script;
    logic        sel;
    logic [7:0]  limit;
    logic [1:0]  lat;
    logic [1:0]  res;
    logic [3:0]  reads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'h0000,             1'b0, 8'd0, 2'd0, 2'd1, 4'd2},
    '{64'h000040,           1'b0, 8'd0, 2'd0, 2'd1, 4'd3},
    '{64'h6020600040,       1'b0, 8'd0, 2'd0, 2'd2, 4'd5},
    '{64'h20202040,         1'b0, 8'd0, 2'd1, 2'd1, 4'd4},
    '{64'h04440044,         1'b1, 8'd0, 2'd0, 2'd1, 4'd4},
    '{64'h0004,             1'b0, 8'd0, 2'd2, 2'd1, 4'd2},
    '{64'h0040004000400040, 1'b0, 8'd3, 2'd0, 2'd3, 4'd3},
    '{64'h20602040,         1'b0, 8'd4, 2'd1, 2'd2, 4'd4},
    '{64'h6020600040,       1'b0, 8'd0, 2'd3, 2'd2, 4'd5},
    '{64'h0000,             1'b0, 8'd2, 2'd0, 2'd1, 4'd2}
  };

  int checks = 0, fails = 0;
  int rdTotal = 0, wrTotal = 0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  int rdBase = 0;
  logic [63:0] script = '0;
  int lat = 0;
  int waitCnt = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (busStrobe && busReady) begin
      if (busWrite) begin
        wrTotal <= wrTotal + 1;
        wrAddr  <= busAddr;
        wrData  <= busWdata;
      end else begin
        rdTotal <= rdTotal + 1;
        rdAddr  <= busAddr;
      end
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      busReady <= 1'b0;
      waitCnt  <= 0;
    end else if (busReady) begin
      busReady <= 1'b0;
      waitCnt  <= 0;
    end else if (busStrobe) begin
      if (waitCnt >= lat) begin
        busReady <= 1'b1;
        if ((rdTotal - rdBase) < 8)
          busRdata <= script[8*(rdTotal - rdBase) +: 8];
        else
          busRdata <= '0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic launch(input logic [63:0] s, input logic sel,
                        input int lim, input int l, output int base, output int wbase);
    @(negedge clk);
    script    = s;
    lat       = l;
    toggleSel = sel;
    pollLimit = CNT_W'(lim);
    base      = rdTotal;
    wbase     = wrTotal;
    rdBase    = rdTotal;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done, req, done, 1);
  endtask

  initial begin
    int base, wbase, res;
    string tag;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busStrobe && !done, "R1", {busStrobe, done}, 0);
    check(!pass && !fail && !limitFail, "R1", {pass, fail, limitFail}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busStrobe && !done, "R1", {busStrobe, done}, 0);

    for (int i = 0; i < NV; i++) begin
      case (i)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R5";
        3: tag = "R4";
        4, 5: tag = "R6";
        6, 7, 9: tag = "R7";
        default: tag = "R9";
      endcase
      launch(VECS[i].script, VECS[i].sel, int'(VECS[i].limit), int'(VECS[i].lat), base, wbase);
      wait_done(tag);
      res = pass ? 1 : fail ? 2 : limitFail ? 3 : 0;
      check(res == int'(VECS[i].res), tag, res, int'(VECS[i].res));
      check(rdTotal - base == int'(VECS[i].reads), tag, rdTotal - base, int'(VECS[i].reads));
      check(rdAddr == ADDR, tag, int'(rdAddr), int'(ADDR));
      if (VECS[i].res == 2'd1) begin
        check(wrTotal == wbase, tag, wrTotal - wbase, 0);
      end else begin
        check(wrTotal - wbase == 1, "R5", wrTotal - wbase, 1);
        check(wrData == 8'hF0 && wrAddr == ADDR, "R5", int'(wrData), 'hF0);
      end
      // R10: verdict held
      repeat (5) @(negedge clk);
      check(done && res == (pass ? 1 : fail ? 2 : limitFail ? 3 : 0), "R10", done, 1);
      check(!busStrobe, "R10", busStrobe, 0);
    end

    // R8: abort mid-poll, then restart from first read pair
    launch(64'h0040004000400040, 1'b0, 0, 1, base, wbase);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!busStrobe, "R8", busStrobe, 0);
    repeat (4) @(negedge clk);
    check(!done && !busStrobe, "R8", {done, busStrobe}, 0);
    check(wrTotal == wbase, "R8", wrTotal - wbase, 0);
    launch(64'h000040, 1'b0, 0, 0, base, wbase);
    wait_done("R8");
    check(pass && rdTotal - base == 3, "R8", rdTotal - base, 3);

    // R10: new start clears the previous verdict
    launch(64'h0040004000400040, 1'b0, 0, 2, base, wbase);
    check(!done && !pass, "R10", {done, pass}, 0);
    wait_done("R3");
    check(pass && rdTotal - base == 9, "R3", rdTotal - base, 9);

    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
    finish_run();
  end

endmodule